// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Manager

This block keeps a two-bank SDRAM's contents alive. A free-running interval counter expires once per refresh slot, where the slot is the retention window divided by the number of rows that must be refreshed in it and then by the clock period. Each expiry adds one to a pending count. While refreshes are pending and the block is idle, it asks the command sequencer for the command bus. The pending count lets the sequencer put refreshes off for a while. Once the count reaches its limit, the block raises an urgent flag so that the sequencer puts refresh ahead of host traffic.

Once granted the bus, the block closes both banks with a precharge-all command. It then waits the precharge time and issues one auto refresh. It holds the bus for the row cycle time after that before handing it back. When the host asks for low power, the block takes the bus in the same way and closes both banks. It then issues the refresh command with the clock enable driven low, which enters self refresh. When the host withdraws the request, the block raises the clock enable and sends only no-operation commands for a full row cycle time. It then issues one auto refresh, waits a row cycle time, and drops its acknowledge.

Top module: `sdr_refresh_mgr`

## Requirements
- R1: While reset is held, cke is 1, the command pins show a no-operation ({cs_n,ras_n,cas_n,we_n} = 4'b0111), and own_bus, ref_req, ref_urgent and sleep_ack are all 0.
- R2: The refresh slot is INTERVAL = WINDOW_NS/ROWS/CLK_NS cycles. After reset, ref_req is 0 for the first INTERVAL-1 clock edges and becomes 1 at edge INTERVAL.
- R3: ref_urgent becomes 1 at the edge where the pending count reaches MAX_PEND, which is edge MAX_PEND*INTERVAL when no grant is given. Before that edge it is 0.
- R4: The pending count saturates at MAX_PEND. Expiries at the limit are dropped, so a backlog is worked off with exactly MAX_PEND refreshes.
- R5: Each granted refresh is a precharge-all ({cs_n,ras_n,cas_n,we_n} = 4'b0010 with a10 = 1), then no-operations, then the auto refresh command (4'b0001 with cke = 1) exactly TRP_CYC cycles after the precharge.
- R6: own_bus stays 1 from the precharge until exactly TRC_CYC cycles after the auto refresh, then returns to 0.
- R7: Each refresh removes one from the pending count. ref_req drops once the count is zero.
- R8: ref_gnt has no effect when nothing is pending and no sleep is requested: own_bus stays 0 and the slot timing is unchanged.
- R9: A sleep request takes priority over pending refreshes. The block issues a precharge-all and, TRP_CYC cycles later, the refresh encoding with cke = 0 in the same cycle. From the next cycle sleep_ack is 1 and cke stays 0 while asleep.
- R10: sleep_req is registered once. One cycle after the request is seen low, cke returns to 1. The block then sends no-operations for TRC_CYC cycles, one auto refresh with cke = 1, and no-operations for TRC_CYC-1 more cycles, after which own_bus and sleep_ack fall together.
- R11: Leaving self refresh restarts the schedule with no refresh pending. ref_req rises exactly INTERVAL edges after own_bus falls.
- R12: cke is 1 in the cycle before every command the block issues.
- R13: ref_req is never 1 while own_bus is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Host request to enter self refresh; dropping it requests exit |
| ref_gnt | input | 1 | Sequencer hands the command bus to this block |
| ref_req | output | 1 | Bus wanted for a refresh or a self-refresh entry |
| ref_urgent | output | 1 | Pending count is at its limit |
| sleep_ack | output | 1 | Memory is in self refresh or still recovering from it |
| own_bus | output | 1 | This block is driving the command pins |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, high selects both banks on precharge |

## Verification
The bench lets the backlog build up past its limit and then counts the refreshes issued under a held grant. A pending counter that wraps instead of saturating would issue far fewer refreshes, and one that keeps counting would issue more. Every gap between precharge, refresh and bus release is measured in cycles. This catches a timer that is off by one and reloaded on the wrong edge, or a clock enable that rises in the same cycle as the exit refresh instead of a full row cycle earlier. The bench also times the first request after reset and after wake-up, so a schedule that is not cleared on leaving self refresh shows up as an early request.

// File: rtl/sdr_rfm_pkg.sv
package sdr_rfm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_PWAIT,
    ST_REF,
    ST_RWAIT,
    ST_SRE,
    ST_SLEEP,
    ST_XWAIT,
    ST_XREF,
    ST_XRC
  } rfm_state_t;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
    logic own;
    logic ack;
  } rfm_pins_t;

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;

  function automatic rfm_pins_t pins_for(input rfm_state_t s);
    rfm_pins_t p;
    p.cke = 1'b1;
    {p.cs_n, p.ras_n, p.cas_n, p.we_n} = CMD_NOP;
    p.a10 = 1'b0;
    p.own = 1'b1;
    p.ack = 1'b0;
    case (s)
      ST_IDLE:  p.own = 1'b0;
      ST_PRE: begin
        {p.cs_n, p.ras_n, p.cas_n, p.we_n} = CMD_PRE;
        p.a10 = 1'b1;
      end
      ST_REF:   {p.cs_n, p.ras_n, p.cas_n, p.we_n} = CMD_REF;
      ST_SRE: begin
        {p.cs_n, p.ras_n, p.cas_n, p.we_n} = CMD_REF;
        p.cke = 1'b0;
      end
      ST_SLEEP: begin
        p.cke = 1'b0;
        p.ack = 1'b1;
      end
      ST_XWAIT, ST_XRC: p.ack = 1'b1;
      ST_XREF: begin
        {p.cs_n, p.ras_n, p.cas_n, p.we_n} = CMD_REF;
        p.ack = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdr_rfm_interval.sv
module sdr_rfm_interval #(
  parameter int INTERVAL = 2604,
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic consume,
  output logic pend_nz,
  output logic pend_full
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);
  localparam logic [PW-1:0] LIMIT  = PW'(MAX_PEND);

  logic [CW-1:0] slot_cnt;
  logic [PW-1:0] pend;
  logic          expire;
  logic          inc;
  logic          dec;

  assign expire    = (slot_cnt == '0) && !clear;
  assign pend_nz   = (pend != '0);
  assign pend_full = (pend == LIMIT);
  assign dec       = consume && pend_nz;
  assign inc       = expire && (!pend_full || dec);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      slot_cnt <= RELOAD;
    end else if (slot_cnt == '0) begin
      slot_cnt <= RELOAD;
    end else begin
      slot_cnt <= slot_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pend <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end
endmodule

// File: rtl/sdr_rfm_delay.sv
module sdr_rfm_delay #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val;
    end else if (!done) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sdr_rfm_fsm.sv
module sdr_rfm_fsm
  import sdr_rfm_pkg::*;
#(
  parameter int TRP_CYC = 3,
  parameter int TRC_CYC = 10,
  parameter int DW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gnt,
  input  logic          sleep_q,
  input  logic          pend_nz,
  input  logic          wait_done,
  output logic          wait_load,
  output logic [DW-1:0] wait_val,
  output logic          consume,
  output logic          sleeping,
  output logic          idle,
  output rfm_pins_t     pins
);
  rfm_state_t state;
  rfm_state_t nxt;
  logic       sr_path;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (gnt && (sleep_q || pend_nz)) nxt = ST_PRE;
      ST_PRE:   nxt = ST_PWAIT;
      ST_PWAIT: if (wait_done) nxt = sr_path ? ST_SRE : ST_REF;
      ST_REF:   nxt = ST_RWAIT;
      ST_RWAIT: if (wait_done) nxt = ST_IDLE;
      ST_SRE:   nxt = ST_SLEEP;
      ST_SLEEP: if (!sleep_q) nxt = ST_XWAIT;
      ST_XWAIT: if (wait_done) nxt = ST_XREF;
      ST_XREF:  nxt = ST_XRC;
      ST_XRC:   if (wait_done) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    wait_load = 1'b0;
    wait_val  = '0;
    case (state)
      ST_PRE: begin
        wait_load = 1'b1;
        wait_val  = DW'(TRP_CYC - 2);
      end
      ST_REF, ST_XREF: begin
        wait_load = 1'b1;
        wait_val  = DW'(TRC_CYC - 2);
      end
      ST_SLEEP: begin
        wait_load = !sleep_q;
        wait_val  = DW'(TRC_CYC - 1);
      end
      default: ;
    endcase
  end

  assign consume  = (state == ST_REF);
  assign idle     = (state == ST_IDLE);
  assign sleeping = (state == ST_SRE) || (state == ST_SLEEP) || (state == ST_XWAIT) ||
                    (state == ST_XREF) || (state == ST_XRC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sr_path <= 1'b0;
      pins    <= pins_for(ST_IDLE);
    end else begin
      state <= nxt;
      pins  <= pins_for(nxt);
      if (state == ST_IDLE && nxt == ST_PRE) sr_path <= sleep_q;
    end
  end
endmodule

// File: rtl/sdr_refresh_mgr.sv
module sdr_refresh_mgr
  import sdr_rfm_pkg::*;
#(
  parameter int CLK_NS    = 6,
  parameter int WINDOW_NS = 32_000_000,
  parameter int ROWS      = 2048,
  parameter int TRP_CYC   = 3,
  parameter int TRC_CYC   = 10,
  parameter int MAX_PEND  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_urgent,
  output logic sleep_ack,
  output logic own_bus,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic a10
);
  localparam int INTERVAL = WINDOW_NS / ROWS / CLK_NS;
  localparam int DMAX     = (TRC_CYC > TRP_CYC) ? TRC_CYC : TRP_CYC;
  localparam int DW       = $clog2(DMAX + 1);

  logic          sleep_q;
  logic          pend_nz;
  logic          pend_full;
  logic          consume;
  logic          sleeping;
  logic          idle;
  logic          wait_load;
  logic [DW-1:0] wait_val;
  logic          wait_done;
  rfm_pins_t     pins;

  always_ff @(posedge clk) begin
    if (rst) sleep_q <= 1'b0;
    else     sleep_q <= sleep_req;
  end

  sdr_rfm_interval #(
    .INTERVAL (INTERVAL),
    .MAX_PEND (MAX_PEND)
  ) u_interval (
    .clk       (clk),
    .rst       (rst),
    .clear     (sleeping),
    .consume   (consume),
    .pend_nz   (pend_nz),
    .pend_full (pend_full)
  );

  sdr_rfm_delay #(
    .W (DW)
  ) u_delay (
    .clk  (clk),
    .rst  (rst),
    .load (wait_load),
    .val  (wait_val),
    .done (wait_done)
  );

  sdr_rfm_fsm #(
    .TRP_CYC (TRP_CYC),
    .TRC_CYC (TRC_CYC),
    .DW      (DW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .gnt       (ref_gnt),
    .sleep_q   (sleep_q),
    .pend_nz   (pend_nz),
    .wait_done (wait_done),
    .wait_load (wait_load),
    .wait_val  (wait_val),
    .consume   (consume),
    .sleeping  (sleeping),
    .idle      (idle),
    .pins      (pins)
  );

  assign ref_req    = idle && (pend_nz || sleep_q);
  assign ref_urgent = pend_full;
  assign sleep_ack  = pins.ack;
  assign own_bus    = pins.own;
  assign cke        = pins.cke;
  assign cs_n       = pins.cs_n;
  assign ras_n      = pins.ras_n;
  assign cas_n      = pins.cas_n;
  assign we_n       = pins.we_n;
  assign a10        = pins.a10;
endmodule

// File: rtl/sdr_refresh_mgr_chk.sv
module sdr_refresh_mgr_chk #(
  parameter int TRP_CYC = 3,
  parameter int TRC_CYC = 10
) (
  input logic clk,
  input logic rst,
  input logic ref_req,
  input logic sleep_ack,
  input logic own_bus,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic a10
);
  logic [3:0]  cmd;
  logic        is_pre;
  logic        is_ref;
  logic [15:0] since_pre;
  logic [15:0] since_ref;

  assign cmd    = {cs_n, ras_n, cas_n, we_n};
  assign is_pre = own_bus && (cmd == 4'b0010) && a10;
  assign is_ref = own_bus && (cmd == 4'b0001);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_pre <= 16'hffff;
      since_ref <= 16'hffff;
    end else begin
      if (is_pre) since_pre <= '0;
      else if (since_pre != 16'hffff) since_pre <= since_pre + 1'b1;
      if (is_ref && cke) since_ref <= '0;
      else if (since_ref != 16'hffff) since_ref <= since_ref + 1'b1;
    end
  end

  // R12
  cke_before_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (own_bus && cmd != 4'b0111) |-> $past(cke));

  // R5
  pre_to_ref_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (is_ref && !sleep_ack) |-> (since_pre == 16'(TRP_CYC - 1)));

  // R6
  release_after_trc_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(own_bus) |-> (since_ref == 16'(TRC_CYC - 1)));

  // R13
  no_req_while_owned_chk: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> !own_bus);

  // R9
  cke_low_only_by_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> is_ref);

  // R9
  cke_low_owned_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |-> own_bus);
endmodule

bind sdr_refresh_mgr sdr_refresh_mgr_chk #(
  .TRP_CYC (TRP_CYC),
  .TRC_CYC (TRC_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_req   (ref_req),
  .sleep_ack (sleep_ack),
  .own_bus   (own_bus),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .a10       (a10)
);

// File: tb/sdr_refresh_mgr_tb.sv
module sdr_refresh_mgr_tb;
  localparam int PERIOD    = 10;
  localparam int CLK_NS    = 10;
  localparam int WINDOW_NS = 2_048_000;
  localparam int ROWS      = 2048;
  localparam int TRP       = 3;
  localparam int TRC       = 6;
  localparam int MAXP      = 8;
  localparam int IVL       = 100;  // 2_048_000 / 2048 / 10

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_urgent, sleep_ack, own_bus, cke, cs_n, ras_n, cas_n, we_n, a10;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sdr_refresh_mgr #(
    .CLK_NS (CLK_NS), .WINDOW_NS (WINDOW_NS), .ROWS (ROWS),
    .TRP_CYC (TRP), .TRC_CYC (TRC), .MAX_PEND (MAXP)
  ) u_dut (
    .clk (clk), .rst (rst), .sleep_req (sleep_req), .ref_gnt (ref_gnt),
    .ref_req (ref_req), .ref_urgent (ref_urgent), .sleep_ack (sleep_ack),
    .own_bus (own_bus), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .a10 (a10)
  );

  function automatic logic [3:0] cmd();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pre_at, ref_at, refs, cyc;
    bit prev_own;
    // R1 reset state
    repeat (3) step();
    chk(cke == 1'b1, "R1 cke", cke, 1);
    chk(cmd() == 4'b0111, "R1 cmd", cmd(), 7);
    chk(own_bus == 1'b0, "R1 own_bus", own_bus, 0);
    chk(ref_req == 1'b0 && ref_urgent == 1'b0, "R1 req/urgent", {ref_req, ref_urgent}, 0);
    chk(sleep_ack == 1'b0, "R1 sleep_ack", sleep_ack, 0);
    rst = 1'b0;

    // R2 / R3 / R8: grant with nothing pending, then let backlog build
    for (int i = 1; i <= 10 * IVL; i++) begin
      ref_gnt = (i < 50);
      step();
      if (i < 52) chk(own_bus == 1'b0, "R8 own_bus under idle grant", own_bus, 0);
      if (i == IVL - 1) chk(ref_req == 1'b0, "R2 req before slot", ref_req, 0);
      if (i == IVL)     chk(ref_req == 1'b1, "R2 req at slot", ref_req, 1);
      if (i == MAXP * IVL - 1) chk(ref_urgent == 1'b0, "R3 urgent early", ref_urgent, 0);
      if (i == MAXP * IVL)     chk(ref_urgent == 1'b1, "R3 urgent at limit", ref_urgent, 1);
    end

    // R4 / R5 / R6 / R7: work off backlog under held grant
    ref_gnt = 1'b1;
    refs = 0; pre_at = -1000; ref_at = -1000; prev_own = 1'b0;
    for (int c = 1; c <= 300; c++) begin
      step();
      if (ref_req && own_bus) chk(1'b0, "R13 req while owned", 1, 0);
      if (own_bus && cmd() == 4'b0010 && a10) pre_at = c;
      else if (own_bus && cmd() == 4'b0001) begin
        chk(cke == 1'b1, "R5 refresh cke", cke, 1);
        chk(c - pre_at == TRP, "R5 precharge-to-refresh gap", c - pre_at, TRP);
        ref_at = c;
        refs++;
      end else if (own_bus && c > pre_at) begin
        chk(cmd() == 4'b0111, "R5 nop between commands", cmd(), 7);
      end
      if (prev_own && !own_bus)
        chk(c - ref_at == TRC, "R6 bus release gap", c - ref_at, TRC);
      prev_own = own_bus;
      if (!own_bus && !ref_req && refs > 0) break;
    end
    chk(refs == MAXP, "R4 refresh count after saturation", refs, MAXP);
    chk(ref_req == 1'b0 && ref_urgent == 1'b0, "R7 req dropped", ref_req, 0);
    ref_gnt = 1'b0;

    // R9: self refresh entry
    repeat (5) step();
    sleep_req = 1'b1;
    ref_gnt = 1'b1;
    pre_at = -1000;
    for (int c = 1; c <= 50; c++) begin
      step();
      if (own_bus && cmd() == 4'b0010 && a10) begin
        pre_at = c;
        ref_gnt = 1'b0;
      end
      if (pre_at > 0 && c == pre_at + TRP) begin
        chk(cmd() == 4'b0001 && own_bus, "R9 entry command", cmd(), 1);
        chk(cke == 1'b0, "R9 cke low with entry", cke, 0);
        chk(sleep_ack == 1'b0, "R9 ack not yet", sleep_ack, 0);
        break;
      end
    end
    chk(pre_at > 0, "R9 precharge seen", pre_at, 1);
    for (int c = 1; c <= 20; c++) begin
      step();
      if (cke !== 1'b0 || sleep_ack !== 1'b1 || ref_req !== 1'b0)
        chk(1'b0, "R9 asleep state", {cke, sleep_ack, ref_req}, 3'b010);
    end
    chk(cke == 1'b0 && sleep_ack == 1'b1, "R9 still asleep", {cke, sleep_ack}, 2'b01);

    // R10 / R12: exit
    sleep_req = 1'b0;
    for (int n = 1; n <= 2 * TRC + 2; n++) begin
      step();
      if (n == 1) chk(cke == 1'b0, "R10 cke still low", cke, 0);
      else if (n <= TRC + 1) begin
        chk(cke == 1'b1 && own_bus && sleep_ack, "R12 cke high before exit refresh", cke, 1);
        chk(cmd() == 4'b0111, "R10 exit nop", cmd(), 7);
      end else if (n == TRC + 2) begin
        chk(cmd() == 4'b0001 && cke == 1'b1, "R10 exit refresh", cmd(), 1);
      end else if (n <= 2 * TRC + 1) begin
        chk(own_bus && sleep_ack && cmd() == 4'b0111, "R10 recovery nop", cmd(), 7);
      end else begin
        chk(own_bus == 1'b0 && sleep_ack == 1'b0, "R10 release", {own_bus, sleep_ack}, 0);
      end
    end

    // R11: schedule restarted
    cyc = 0;
    for (int i = 1; i <= IVL; i++) begin
      step();
      if (i == IVL - 1) chk(ref_req == 1'b0, "R11 no request early", ref_req, 0);
      if (i == IVL)     chk(ref_req == 1'b1, "R11 request at slot", ref_req, 1);
      cyc++;
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule